// File: doc/BRIEF.md
# Serial Audio Slot Serializer

This block turns one parallel audio sample per frame into a serial bit stream for a converter that expects two 16-bit slots per frame: a left slot while the word-select line is low and a right slot while it is high. The serial clock runs at 32 times the sample rate. All state changes on the falling edge of the serial clock, so each bit is stable across the rising edge, where the converter samples it.

When the word-select line goes from high to low, the block first notes the fall. On the next falling serial-clock edge it loads the sample into a 32-bit shift register. The sample goes into the top of the register and every lower bit is cleared. From then on, each falling edge moves the register one place towards the MSB and feeds a zero in at the bottom. The serial output is always the register's top bit. As a result, the left slot carries the 8-bit sample left-justified, and the remainder of the frame, including the whole right slot, is zero. The parallel input is read only on the load edge, so it has to be held steady from the word-select fall until that edge.

Top module: `i2s_dac_serializer`

## Requirements
- R1: While `rstN` is low, `sdata` is 0. After reset is released, `sdata` stays 0 until the first load.
- R2: `lrclk` is registered on every falling `sclk` edge. A fall is detected on the falling edge where the registered copy is 1 and `lrclk` is 0.
- R3: The sample is loaded on the falling `sclk` edge that follows the detecting edge. `sample[7]` appears on `sdata` right after that load edge.
- R4: After the load, the sample bits leave MSB first, one bit per falling `sclk` edge: `sample[7]` down to `sample[0]` on 8 consecutive edges.
- R5: The 24 bits that follow the sample in the 32-bit register are 0. The rest of the left slot and the whole right slot therefore carry 0 on `sdata`.
- R6: A change on `sample` on any edge other than the load edge has no effect on the bits sent.
- R7: While `lrclk` stays at one level, no load takes place. Once the register has emptied, `sdata` stays 0.
- R8: A rising edge of `lrclk` never causes a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock; all state changes on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Word select: low marks the left slot, high the right slot |
| sample | input | 8 | Parallel sample; read on the load edge only |
| sdata | output | 1 | Serial data; top bit of the shift register |

## Verification
The serializer is driven with regular 32-bit frames of varied samples: alternating bits, a lone MSB, a lone LSB, all ones and all zeros. These separate a wrong bit order, a wrong slot offset and missing zero fill. Some frames change the parallel input on every cycle after the load edge, which exposes a design that reads the sample late or keeps re-loading it. Long stretches with the word-select held high, then held low, then rising, show that only a falling edge starts a load. A reset in the middle of a frame shows that the output drops to zero at once.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;

  // Strobes from the control to the datapath, valid for the next falling sclk edge.
  typedef struct packed {
    logic loadSample;  // capture the parallel sample into the top of the register
    logic shiftOut;    // move the register one place towards the MSB, zero in at the bottom
  } serStrobe_t;

endpackage

// File: rtl/dac_ser_ctrl.sv
module dac_ser_ctrl
  import dac_ser_pkg::*;
(
  input  logic       sclk,
  input  logic       rstN,
  input  logic       lrclk,
  output serStrobe_t strobe
);

  logic lrPrev;  // lrclk as seen on the previous falling sclk edge
  logic armed;   // a falling lrclk was seen; load on the next edge
  logic lrFall;

  assign lrFall = lrPrev & ~lrclk;

  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN) begin
      lrPrev <= 1'b0;
      armed  <= 1'b0;
    end else begin
      lrPrev <= lrclk;
      armed  <= lrFall;
    end
  end

  always_comb begin
    strobe.loadSample = armed;
    strobe.shiftOut   = ~armed;
  end

  // R2: a fall seen against the registered copy arms the load
  p_arm_after_fall_r2: assert property (@(negedge sclk) disable iff (!rstN)
    (lrPrev && !lrclk) |=> armed);

  // R3: the load strobe lasts exactly one edge
  p_arm_single_r3: assert property (@(negedge sclk) disable iff (!rstN)
    armed |=> !armed);

  // R8: lrclk high on an edge never leads to a load on the next
  p_no_arm_when_high_r8: assert property (@(negedge sclk) disable iff (!rstN)
    lrclk |=> !strobe.loadSample);

endmodule

// File: rtl/dac_ser_dp.sv
module dac_ser_dp
  import dac_ser_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int SLOT_W   = 16
) (
  input  logic                sclk,
  input  logic                rstN,
  input  serStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                sdata
);

  localparam int FRAME_W = 2 * SLOT_W;
  localparam int PAD_W   = FRAME_W - SAMPLE_W;

  logic [FRAME_W-1:0] shReg;
  logic [FRAME_W-1:0] loadWord;

  // Left-justify the sample; everything below it is zero.
  for (genvar b = 0; b < FRAME_W; b++) begin : g_word
    if (b >= PAD_W) begin : g_data
      assign loadWord[b] = sample[b-PAD_W];
    end else begin : g_pad
      assign loadWord[b] = 1'b0;
    end
  end

  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobe.loadSample) begin
      shReg <= loadWord;
    end else if (strobe.shiftOut) begin
      shReg <= {shReg[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdata = shReg[FRAME_W-1];

  // R1: output quiet while reset is held
  always @(negedge sclk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (sdata == 1'b0);
    end
  end

  // R3: the sample MSB is on the line right after the load edge
  p_msb_first_r3: assert property (@(negedge sclk) disable iff (!rstN)
    strobe.loadSample |=> (sdata == $past(sample[SAMPLE_W-1])));

  // R4: each shift presents the bit that sat just below the top
  p_bit_walk_r4: assert property (@(negedge sclk) disable iff (!rstN)
    strobe.shiftOut |=> (sdata == $past(shReg[FRAME_W-2])));

  // R5: the bits under the sample are zero after a load
  p_zero_fill_r5: assert property (@(negedge sclk) disable iff (!rstN)
    strobe.loadSample |=> (shReg[PAD_W-1:0] == '0));

  // R7: an empty register stays empty without a load
  p_stay_silent_r7: assert property (@(negedge sclk) disable iff (!rstN)
    (strobe.shiftOut && shReg == '0) |=> (sdata == 1'b0));

endmodule

// File: rtl/i2s_dac_serializer.sv
module i2s_dac_serializer
  import dac_ser_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int SLOT_W   = 16
) (
  input  logic                sclk,
  input  logic                rstN,
  input  logic                lrclk,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                sdata
);

  serStrobe_t strobe;

  dac_ser_ctrl u_ctrl (
    .sclk   (sclk),
    .rstN   (rstN),
    .lrclk  (lrclk),
    .strobe (strobe)
  );

  dac_ser_dp #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_W   (SLOT_W)
  ) u_dp (
    .sclk   (sclk),
    .rstN   (rstN),
    .strobe (strobe),
    .sample (sample),
    .sdata  (sdata)
  );

endmodule

// File: tb/i2s_dac_serializer_tb.sv
`timescale 1ns/1ps
module i2s_dac_serializer_tb;

  logic       sclk  = 1'b0;
  logic       rstN  = 1'b0;
  logic       lrclk = 1'b1;
  logic [7:0] sample = 8'h00;
  logic       sdata;

  int    nChecks = 0;
  int    nFail   = 0;
  string scen    = "";
  bit    finished = 1'b0;

  always #2.5 sclk = ~sclk;

  i2s_dac_serializer u_dut (
    .sclk   (sclk),
    .rstN   (rstN),
    .lrclk  (lrclk),
    .sample (sample),
    .sdata  (sdata)
  );

  // Behavioural reference: a queue of pending bits, refilled on each load
  bit q[$];
  bit mPrev  = 1'b0;
  bit mArmed = 1'b0;
  int bitPos = -1;

  always @(negedge sclk) begin
    bit wasArmed;
    if (!rstN) begin
      q.delete();
      mPrev  = 1'b0;
      mArmed = 1'b0;
      bitPos = -1;
    end else begin
      wasArmed = mArmed;
      mArmed   = (mPrev == 1'b1) && (lrclk == 1'b0);
      mPrev    = lrclk;
      if (wasArmed) begin
        q.delete();
        for (int i = 7; i >= 0; i--) q.push_back(sample[i]);
        repeat (24) q.push_back(1'b0);
        bitPos = 0;
      end else begin
        if (q.size() > 0) void'(q.pop_front());
        if (bitPos >= 0) bitPos++;
      end
    end
  end

  function automatic string phaseTag();
    if (bitPos < 0) return "R1";
    if (bitPos == 0) return "R3";
    if (bitPos < 8) return "R4";
    return "R5";
  endfunction

  task automatic tick(input string force_tag);
    bit    expBit;
    string tag;
    @(posedge sclk);
    expBit = (q.size() > 0) ? q[0] : 1'b0;
    if (force_tag != "") tag = force_tag;
    else if (scen != "") tag = scen;
    else tag = phaseTag();
    nChecks++;
    if (sdata !== expBit) begin
      nFail++;
      $display("FAIL %s: sdata=%b expected %b at %0t", tag, sdata, expBit, $time);
    end
  endtask

  // One 32-cycle frame: lrclk falls at the start, rises after 16 cycles
  task automatic frame(input logic [7:0] v, input bit wiggle);
    tick("");
    lrclk  = 1'b0;
    sample = v;
    for (int i = 1; i < 32; i++) begin
      tick("");
      if (i == 16) lrclk = 1'b1;
      if (wiggle && i >= 3) sample = 8'($urandom);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (4) tick("R1");
    rstN = 1'b1;
    repeat (4) tick("R1");

    // R2 R3 R4 R5: plain frames with distinct patterns
    frame(8'hA5, 1'b0);
    frame(8'h80, 1'b0);
    frame(8'h01, 1'b0);
    frame(8'hFF, 1'b0);
    frame(8'h00, 1'b0);

    // R6: input changes after the load edge
    scen = "R6";
    frame(8'h7E, 1'b1);
    frame(8'hC3, 1'b1);
    scen = "";
    frame(8'h5A, 1'b0);

    // R7: lrclk held high, then low, with the input moving
    scen = "R7";
    for (int i = 0; i < 40; i++) begin
      tick("");
      sample = 8'($urandom);
    end
    lrclk  = 1'b0;
    sample = 8'h96;
    for (int i = 0; i < 40; i++) begin
      tick("");
      if (i > 2) sample = 8'($urandom);
    end

    // R8: rising lrclk only
    scen = "R8";
    lrclk = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick("");
      sample = 8'($urandom);
    end
    scen = "";

    // R1: reset in the middle of a frame
    tick("");
    lrclk  = 1'b0;
    sample = 8'hFF;
    repeat (5) tick("");
    rstN = 1'b0;
    repeat (3) tick("R1");
    rstN  = 1'b1;
    lrclk = 1'b1;
    repeat (4) tick("R1");

    frame(8'hB1, 1'b0);
    frame(8'h3C, 1'b0);
    repeat (4) tick("");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule